// File: doc/BRIEF.md
# Duty-Cycled Receiver Wake Sequencer

This block schedules low-power listening for a packet receiver. A free-running wake timer, counted in timer units of a fixed number of clock cycles, turns the receive chain on once per programmed period. Each wake starts with an optional warm-up delay that covers oscillator and synthesizer settling. A listen window follows. Its length is an odd number of timer units taken from a 7-bit field. Outside these windows the receiver is powered down.

While the signal-quality input reports a good signal, the window is held open beyond its programmed length. When valid data is flagged, the block raises an interrupt to the host and keeps the receiver powered while the receive FIFO fills. After the signal ends it waits for the host to drain the FIFO. The host then acknowledges with the FIFO empty, which clears the interrupt and returns the block to sleep. The wake timer keeps its phase through every window, so wake-ups stay on a fixed grid. A zero period, or a window longer than the period, turns the block into a continuous listener.

Top module: `rxw_sequencer`

## Requirements
- R1: After reset `rx_power_en` and `host_irq` are 0. `rx_power_en` is 1 in every state except sleep, and `host_irq` is only ever 1 while `rx_power_en` is 1.
- R2: With duty cycling allowed, `rx_power_en` rises first `wake_period`×`TICK_DIV` cycles after duty cycling becomes allowed, and then once every `wake_period`×`TICK_DIV` cycles.
- R3: With no signal activity, a window keeps `rx_power_en` high for (`warmup_units` + 2×`listen_field[7:1]` + 1)×`TICK_DIV` cycles. Bit 0 of `listen_field` has no effect.
- R4: `sig_good` is ignored during the `warmup_units` warm-up units, and the window length is unchanged by it.
- R5: When `sig_good` is 1 in the listen phase, the receiver stays powered for as long as `sig_good` stays 1, even past the programmed window.
- R6: If `sig_good` drops while the window is held open and no valid data has been seen, `rx_power_en` is 0 on the next cycle. The next wake still falls on the original period grid.
- R7: `data_valid` during the listen or hold phase sets `host_irq` on the next cycle. `data_valid` while asleep or in warm-up is ignored.
- R8: After valid data, `rx_power_en` stays 1 after `sig_good` drops, until `host_ack` and `fifo_empty` are both 1 in one cycle. On the next cycle `host_irq` and `rx_power_en` are both 0.
- R9: `host_ack` has no effect while `fifo_empty` is 0, or while `sig_good` still holds the receiver in the hold phase.
- R10: Duty cycling is allowed only when `wake_tmr_en` is 1 and `cont_rx_en` is 0. Otherwise the block stays asleep with `rx_power_en` 0.
- R11: If `wake_period` is 0, or 2×`listen_field[7:1]`+1 exceeds `wake_period`, the receiver listens continuously and `rx_power_en` stays 1.
- R12: If `data_valid` is 1 in the same cycle that `sig_good` drops during the hold phase, that data counts. `host_irq` rises and the block waits for the drain instead of sleeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_period | input | 8 | Wake period in timer units (0 = continuous) |
| listen_field | input | 8 | Bits 7:1 set the window to 2×value+1 units; bit 0 unused |
| warmup_units | input | 4 | Warm-up delay in timer units at each wake |
| cont_rx_en | input | 1 | Continuous receive enable (must be 0 for duty cycling) |
| wake_tmr_en | input | 1 | Wake timer enable (must be 1 for duty cycling) |
| sig_good | input | 1 | Signal-quality indicator from the receive chain |
| data_valid | input | 1 | Valid received data strobe |
| fifo_empty | input | 1 | Receive FIFO is empty |
| host_ack | input | 1 | Host interrupt acknowledge |
| rx_power_en | output | 1 | Receive chain power enable |
| host_irq | output | 1 | Interrupt to the host |

## Verification
Two pairs of events can fall in one cycle. The first is a valid-data strobe on the same edge where signal quality drops during the hold phase. The bench holds the receiver open with `sig_good`, then in one cycle raises `data_valid` and lowers `sig_good`. It judges the result correct if `host_irq` rises and the receiver stays powered well past the window, waiting for the drain. The second is an acknowledge that arrives while the hold phase is still active. The bench pulses `host_ack` with the FIFO empty while `sig_good` is 1, and checks that the interrupt and power stay up.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  localparam int RXW_PER_W = 8;
  localparam int RXW_SU_W  = 4;

  typedef enum logic [2:0] {
    ST_SLEEP   = 3'd0,
    ST_STARTUP = 3'd1,
    ST_LISTEN  = 3'd2,
    ST_RECEIVE = 3'd3,
    ST_DRAIN   = 3'd4
  } rxw_state_t;

  // Odd window length: twice the upper seven bits plus one.
  function automatic logic [RXW_PER_W-1:0] window_units(input logic [RXW_PER_W-1:0] field);
    return {field[RXW_PER_W-1:1], 1'b1};
  endfunction

  // Continuous listening when the timer is off or the window cannot fit.
  function automatic logic listen_forever(input logic [RXW_PER_W-1:0] period,
                                          input logic [RXW_PER_W-1:0] win);
    return (period == '0) || (win > period);
  endfunction

  // Duty cycling is allowed only with timer on and continuous receive off.
  function automatic logic duty_allowed(input logic tmr_en, input logic cont_en);
    return tmr_en && !cont_en;
  endfunction

endpackage

// File: rtl/rxw_prescaler.sv
module rxw_prescaler #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  generate
    if (TICK_DIV == 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      logic [CW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           div_q <= '0;
        else if (!run)        div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                  div_q <= div_q + 1'b1;
      end
      assign tick = run && (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/rxw_phase_timer.sv
module rxw_phase_timer #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  output logic             wake
);
  logic [PER_W-1:0] phase_q;
  logic             at_end;

  assign at_end = (phase_q == period - 1'b1);
  assign wake   = tick && (period != '0) && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= '0;
    else if (!run)            phase_q <= '0;
    else if (tick) begin
      if (at_end || period == '0) phase_q <= '0;
      else                        phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxw_unit_counter.sv
module rxw_unit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last = tick && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/rxw_fsm.sv
module rxw_fsm
  import rxw_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int SU_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wake,
  input  logic             forever_mode,
  input  logic [SU_W-1:0]  warmup,
  input  logic [PER_W-1:0] win,
  input  logic             cnt_last,
  input  logic             sig_good,
  input  logic             data_valid,
  input  logic             fifo_empty,
  input  logic             host_ack,
  output logic             load,
  output logic [PER_W-1:0] load_val,
  output rxw_state_t       state,
  output logic             irq
);
  rxw_state_t state_q, state_d;
  logic       seen_q, seen_d, irq_q, irq_d;
  logic       drain_done;

  assign drain_done = host_ack && fifo_empty;

  always_comb begin
    state_d  = state_q;
    seen_d   = seen_q;
    irq_d    = irq_q;
    load     = 1'b0;
    load_val = win;
    unique case (state_q)
      ST_SLEEP: begin
        if (run && (wake || forever_mode)) begin
          load = 1'b1;
          if (warmup != '0) begin
            state_d  = ST_STARTUP;
            load_val = PER_W'(warmup);
          end else begin
            state_d = ST_LISTEN;
          end
        end
      end
      ST_STARTUP: begin
        if (!run)          state_d = ST_SLEEP;
        else if (cnt_last) begin
          state_d = ST_LISTEN;
          load    = 1'b1;
        end
      end
      ST_LISTEN: begin
        if (!run) state_d = ST_SLEEP;
        else if (data_valid) begin
          state_d = ST_RECEIVE;
          seen_d  = 1'b1;
          irq_d   = 1'b1;
        end else if (sig_good) begin
          state_d = ST_RECEIVE;
        end else if (cnt_last) begin
          if (forever_mode) load = 1'b1;
          else              state_d = ST_SLEEP;
        end
      end
      ST_RECEIVE: begin
        if (data_valid) begin
          seen_d = 1'b1;
          irq_d  = 1'b1;
        end
        if (!sig_good) begin
          if (seen_q || data_valid) state_d = ST_DRAIN;
          else                      state_d = ST_SLEEP;
        end
      end
      ST_DRAIN: begin
        if (drain_done) begin
          state_d = ST_SLEEP;
          seen_d  = 1'b0;
          irq_d   = 1'b0;
        end
      end
      default: state_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SLEEP;
      seen_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
      irq_q   <= irq_d;
    end
  end

  assign state = state_q;
  assign irq   = irq_q;
endmodule

// File: rtl/rxw_sequencer.sv
module rxw_sequencer
  import rxw_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int PER_W    = RXW_PER_W,
  parameter int SU_W     = RXW_SU_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] wake_period,
  input  logic [PER_W-1:0] listen_field,
  input  logic [SU_W-1:0]  warmup_units,
  input  logic             cont_rx_en,
  input  logic             wake_tmr_en,
  input  logic             sig_good,
  input  logic             data_valid,
  input  logic             fifo_empty,
  input  logic             host_ack,
  output logic             rx_power_en,
  output logic             host_irq
);
  logic             run_ok;
  logic             unit_tick;
  logic             wake_evt;
  logic             forever_mode;
  logic [PER_W-1:0] win_units;
  logic             cnt_load;
  logic [PER_W-1:0] cnt_val;
  logic             cnt_last;
  rxw_state_t       state_q;
  logic             listening;

  assign run_ok       = duty_allowed(wake_tmr_en, cont_rx_en);
  assign win_units    = window_units(listen_field);
  assign forever_mode = listen_forever(wake_period, win_units);

  rxw_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run_ok), .tick(unit_tick)
  );

  rxw_phase_timer #(.PER_W(PER_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run_ok), .tick(unit_tick),
    .period(wake_period), .wake(wake_evt)
  );

  rxw_unit_counter #(.CNT_W(PER_W)) u_units (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .tick(unit_tick), .last(cnt_last)
  );

  rxw_fsm #(.PER_W(PER_W), .SU_W(SU_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run(run_ok), .wake(wake_evt),
    .forever_mode(forever_mode), .warmup(warmup_units), .win(win_units),
    .cnt_last(cnt_last), .sig_good(sig_good), .data_valid(data_valid),
    .fifo_empty(fifo_empty), .host_ack(host_ack),
    .load(cnt_load), .load_val(cnt_val), .state(state_q), .irq(host_irq)
  );

  assign rx_power_en = (state_q != ST_SLEEP);
  assign listening   = (state_q == ST_LISTEN) || (state_q == ST_RECEIVE);
endmodule

// File: rtl/rxw_sequencer_chk.sv
module rxw_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_power_en,
  input logic host_irq,
  input logic host_ack,
  input logic fifo_empty,
  input logic data_valid,
  input logic run_ok,
  input logic wake_evt,
  input logic forever_mode,
  input logic listening
);
  assert_irq_needs_power_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> rx_power_en);

  assert_wake_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_power_en) |-> $past(wake_evt || forever_mode));

  assert_data_raises_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (listening && data_valid) |=> host_irq);

  assert_irq_clear_on_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_irq) |-> $past(host_ack && fifo_empty));

  assert_disabled_stays_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_ok && !rx_power_en) |=> !rx_power_en);

  assert_irq_rise_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(data_valid));
endmodule

bind rxw_sequencer rxw_sequencer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_power_en(rx_power_en), .host_irq(host_irq),
  .host_ack(host_ack), .fifo_empty(fifo_empty), .data_valid(data_valid),
  .run_ok(run_ok), .wake_evt(wake_evt), .forever_mode(forever_mode),
  .listening(listening)
);

// File: tb/rxw_sequencer_tb_top.sv
module rxw_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TD         = 4;
  localparam int NVEC       = 7;

  // {period, field, warmup, expected high cycles (0 = continuous), expected gap}
  typedef struct packed {
    logic [7:0]  per;
    logic [7:0]  fld;
    logic [3:0]  su;
    logic [15:0] high;
    logic [15:0] gap;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'd20, 8'h06, 4'd0, 16'd28,  16'd80},
    '{8'd20, 8'h07, 4'd0, 16'd28,  16'd80},
    '{8'd30, 8'h00, 4'd2, 16'd12,  16'd120},
    '{8'd16, 8'h0A, 4'd3, 16'd56,  16'd64},
    '{8'd40, 8'h26, 4'd0, 16'd156, 16'd160},
    '{8'd12, 8'h18, 4'd0, 16'd0,   16'd0},
    '{8'd0,  8'h04, 4'd1, 16'd0,   16'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] wake_period = '0, listen_field = '0;
  logic [3:0] warmup_units = '0;
  logic cont_rx_en = 1'b0, wake_tmr_en = 1'b0, sig_good = 1'b0;
  logic data_valid = 1'b0, fifo_empty = 1'b0, host_ack = 1'b0;
  logic rx_power_en, host_irq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rxw_sequencer #(.TICK_DIV(TD)) dut_i (
    .clk(clk), .rst_n(rst_n), .wake_period(wake_period), .listen_field(listen_field),
    .warmup_units(warmup_units), .cont_rx_en(cont_rx_en), .wake_tmr_en(wake_tmr_en),
    .sig_good(sig_good), .data_valid(data_valid), .fifo_empty(fifo_empty),
    .host_ack(host_ack), .rx_power_en(rx_power_en), .host_irq(host_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Own restatement of the window rule: warm-up plus odd window, in cycles.
  function automatic int exp_high(input int su, input int fld);
    return (su + (fld / 2) * 2 + 1) * TD;
  endfunction

  task automatic wait_rise(output int t, input int limit);
    int n = 0;
    while (!rx_power_en && n < limit) begin step(); n++; end
    t = cyc;
  endtask

  task automatic wait_fall(output int t, input int limit);
    int n = 0;
    while (rx_power_en && n < limit) begin step(); n++; end
    t = cyc;
  endtask

  task automatic configure(input int per, input int fld, input int su);
    @(negedge clk);
    wake_tmr_en = 1'b0; cont_rx_en = 1'b0;
    sig_good = 1'b0; data_valid = 1'b0; host_ack = 1'b0; fifo_empty = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wake_period = 8'(per); listen_field = 8'(fld); warmup_units = 4'(su);
    wake_tmr_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2;
    repeat (3) step();
    check(rx_power_en == 1'b0 && host_irq == 1'b0, "R1 reset state", rx_power_en, 0);
    @(negedge clk); rst_n = 1'b1;

    // Table walk: window length and wake spacing
    for (int i = 0; i < NVEC; i++) begin
      configure(VECS[i].per, VECS[i].fld, VECS[i].su);
      wait_rise(t0, 2000);
      if (VECS[i].high == 0) begin
        wait_fall(t1, 300);
        check(rx_power_en == 1'b1, "R11 continuous listen", t1 - t0, 300);
      end else begin
        wait_fall(t1, 2000);
        check((t1 - t0) == int'(VECS[i].high) &&
              int'(VECS[i].high) == exp_high(VECS[i].su, VECS[i].fld),
              "R3 window length", t1 - t0, exp_high(VECS[i].su, VECS[i].fld));
        wait_rise(t2, 2000);
        check((t2 - t0) == int'(VECS[i].gap), "R2 wake period", t2 - t0, VECS[i].gap);
      end
    end

    // R10: duty cycling blocked by continuous receive or timer off
    configure(10, 2, 0);
    @(negedge clk); cont_rx_en = 1'b1;
    wait_rise(t0, 200);
    check(rx_power_en == 1'b0, "R10 continuous-rx blocks wakes", rx_power_en, 0);
    @(negedge clk); cont_rx_en = 1'b0; wake_tmr_en = 1'b0;
    wait_rise(t0, 200);
    check(rx_power_en == 1'b0, "R10 timer off blocks wakes", rx_power_en, 0);

    // R7: data while asleep ignored; R5/R6 extension, abort and phase
    configure(40, 8'h04, 0);
    repeat (10) step();
    @(negedge clk); data_valid = 1'b1;
    @(negedge clk); data_valid = 1'b0;
    step();
    check(host_irq == 1'b0, "R7 data while asleep ignored", host_irq, 0);
    wait_rise(t0, 400);
    @(negedge clk); sig_good = 1'b1;
    repeat (60) step();
    check(rx_power_en == 1'b1, "R5 window held by quality", rx_power_en, 1);
    @(negedge clk); sig_good = 1'b0;
    step();
    check(rx_power_en == 1'b0 && host_irq == 1'b0, "R6 sleep on quality drop", rx_power_en, 0);
    wait_rise(t1, 400);
    check((t1 - t0) == 160, "R6 phase kept", t1 - t0, 160);

    // R7/R8/R9: data, drain, acknowledge rules
    repeat (2) step();
    @(negedge clk); sig_good = 1'b1; data_valid = 1'b1;
    @(negedge clk); data_valid = 1'b0;
    check(host_irq == 1'b1, "R7 irq on data", host_irq, 1);
    @(negedge clk); host_ack = 1'b1; fifo_empty = 1'b1;
    @(negedge clk); host_ack = 1'b0; fifo_empty = 1'b0;
    step();
    check(host_irq == 1'b1 && rx_power_en == 1'b1, "R9 ack ignored while held", host_irq, 1);
    @(negedge clk); sig_good = 1'b0;
    repeat (40) step();
    check(rx_power_en == 1'b1 && host_irq == 1'b1, "R8 power held for drain", rx_power_en, 1);
    @(negedge clk); host_ack = 1'b1;
    @(negedge clk); host_ack = 1'b0;
    step();
    check(host_irq == 1'b1, "R9 ack ignored with FIFO not empty", host_irq, 1);
    @(negedge clk); host_ack = 1'b1; fifo_empty = 1'b1;
    step();
    check(host_irq == 1'b0 && rx_power_en == 1'b0, "R8 clear on ack with empty", host_irq, 0);
    @(negedge clk); host_ack = 1'b0; fifo_empty = 1'b0;

    // R12: data and quality drop in the same cycle
    wait_rise(t0, 400);
    @(negedge clk); sig_good = 1'b1;
    repeat (3) step();
    @(negedge clk); sig_good = 1'b0; data_valid = 1'b1;
    @(negedge clk); data_valid = 1'b0;
    check(host_irq == 1'b1, "R12 irq on coincident data", host_irq, 1);
    repeat (40) step();
    check(rx_power_en == 1'b1, "R12 waits for drain", rx_power_en, 1);
    @(negedge clk); host_ack = 1'b1; fifo_empty = 1'b1;
    @(negedge clk); host_ack = 1'b0; fifo_empty = 1'b0;

    // R4: quality during warm-up ignored; R7: data during warm-up ignored
    configure(40, 8'h04, 3);
    wait_rise(t0, 400);
    @(negedge clk); sig_good = 1'b1; data_valid = 1'b1;
    @(negedge clk); data_valid = 1'b0;
    repeat (4) step();
    @(negedge clk); sig_good = 1'b0;
    check(host_irq == 1'b0, "R7 data in warm-up ignored", host_irq, 0);
    wait_fall(t1, 400);
    check((t1 - t0) == exp_high(3, 4), "R4 warm-up ignores quality", t1 - t0, exp_high(3, 4));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule